// File: doc/BRIEF.md
# Interrupt Line Steering Router

This block sits between eight level-sensitive PCI interrupt lines (PIRQ0..PIRQ7, also called PIRQA..PIRQH) and the two interrupt controllers of a system: a 16-input legacy controller and a 24-input advanced controller. A power-management event line (SCI) is steered in as well. On the advanced side the mapping is fixed: PIRQ n always feeds line 16 + n. On the legacy side each PIRQ goes through a programmable route byte. The route byte names one of the 16 legacy lines or removes that PIRQ from legacy routing. Any legacy line that several sources select carries the OR of those sources.

A small write-only register file holds the eight route bytes and a 3-bit SCI destination code. The SCI can be steered to interrupt 9, 10, 11, 20 or 21. A reserved code leaves it unconnected. Each controller output is registered. A change on an input or in the register file therefore reaches the outputs one clock later.

Top module: `irq_steer_router`

## Requirements
- R1: While `rst_n` is low, and after it rises, every output is 0. Every route byte starts disabled and the SCI code starts at 0 (interrupt 9).
- R2: When `cfg_we` is high at a clock edge, address n (0..7) loads route byte n. In that byte, bit 7 is the disable flag and bits [3:0] select the legacy line. Address 8 loads the SCI code from bits [2:0]. Addresses 9..15 change nothing.
- R3: Legacy line k is the OR of every PIRQ whose route is enabled and selects k. Sources that share a line are ORed.
- R4: A PIRQ whose route byte has bit 7 set drives no legacy line.
- R5: Advanced line 16 + n follows PIRQ n, whatever the route bytes hold.
- R6: SCI codes 0, 1, 2, 4 and 5 steer the SCI to interrupt 9, 10, 11, 20 and 21. The SCI is ORed into the advanced line of that number.
- R7: SCI codes 3, 6 and 7 connect the SCI to no output.
- R8: The SCI reaches the legacy line of its number only when that number is below 16. For 20 and 21 it reaches the advanced side alone.
- R9: Each output reflects the inputs and register contents of the previous clock edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pirq_i | input | 8 | PCI interrupt levels, bit n is PIRQ n |
| sci_i | input | 1 | Power-management event level |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| pic_o | output | 16 | Registered legacy controller lines |
| apic_o | output | 24 | Registered advanced controller lines |

## Verification
The assertions assume that the inputs and the register file are stable across a clock edge. A property that compares an output with the previous cycle's inputs is only valid under that assumption. The bench drives every input and every register write on the falling edge, so each value has a full half period to settle before the rising edge samples it. The checks are made one full cycle after the write's commit edge, which keeps each route or SCI code change separate from the output it produces.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

  localparam int ROUTE_LINE_W = 4;
  localparam int SCI_SEL_W    = 3;
  localparam int IRQ_NUM_W    = 5;

  typedef struct packed {
    logic                    dis;
    logic [ROUTE_LINE_W-1:0] line;
  } route_t;

  localparam route_t              ROUTE_RST   = '{dis: 1'b1, line: '0};
  localparam logic [SCI_SEL_W-1:0] SCI_SEL_RST = '0;

  // returns {valid, irq number}
  function automatic logic [IRQ_NUM_W:0] sci_decode(input logic [SCI_SEL_W-1:0] sel);
    case (sel)
      3'd0:    sci_decode = {1'b1, 5'd9};
      3'd1:    sci_decode = {1'b1, 5'd10};
      3'd2:    sci_decode = {1'b1, 5'd11};
      3'd4:    sci_decode = {1'b1, 5'd20};
      3'd5:    sci_decode = {1'b1, 5'd21};
      default: sci_decode = '0;
    endcase
  endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_steer_pkg::*;
#(
  parameter int NUM_PIRQ = 8,
  parameter int AW       = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [AW-1:0]                addr,
  input  logic [7:0]                   wdata,
  output route_t [NUM_PIRQ-1:0]        route_o,
  output logic   [SCI_SEL_W-1:0]       sci_sel_o
);

  route_t [NUM_PIRQ-1:0]  route_q, route_d;
  logic [SCI_SEL_W-1:0]   sel_q, sel_d;
  logic                   unused_wbits;

  assign unused_wbits = ^wdata[6:4];

  always_comb begin
    route_d = route_q;
    sel_d   = sel_q;
    if (we) begin
      for (int n = 0; n < NUM_PIRQ; n++) begin
        if (addr == AW'(n)) route_d[n] = '{dis: wdata[7], line: wdata[ROUTE_LINE_W-1:0]};
      end
      if (addr == AW'(NUM_PIRQ)) sel_d = wdata[SCI_SEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= {NUM_PIRQ{ROUTE_RST}};
      sel_q   <= SCI_SEL_RST;
    end else if (we) begin
      route_q <= route_d;
      sel_q   <= sel_d;
    end
  end

  assign route_o   = route_q;
  assign sci_sel_o = sel_q;

endmodule

// File: rtl/irq_pic_mux.sv
module irq_pic_mux
  import irq_steer_pkg::*;
#(
  parameter int NUM_PIRQ  = 8,
  parameter int PIC_LINES = 16
) (
  input  logic [NUM_PIRQ-1:0]  pirq_i,
  input  route_t [NUM_PIRQ-1:0] route_i,
  input  logic                 sci_i,
  input  logic                 sci_pic_i,
  input  logic [IRQ_NUM_W-1:0] sci_num_i,
  output logic [PIC_LINES-1:0] pic_o
);

  for (genvar k = 0; k < PIC_LINES; k++) begin : g_line
    logic line_hit;
    always_comb begin
      line_hit = sci_i && sci_pic_i && (sci_num_i == IRQ_NUM_W'(k));
      for (int n = 0; n < NUM_PIRQ; n++) begin
        if (!route_i[n].dis && route_i[n].line == ROUTE_LINE_W'(k) && pirq_i[n])
          line_hit = 1'b1;
      end
    end
    assign pic_o[k] = line_hit;
  end

endmodule

// File: rtl/irq_apic_map.sv
module irq_apic_map
  import irq_steer_pkg::*;
#(
  parameter int NUM_PIRQ   = 8,
  parameter int APIC_LINES = 24,
  parameter int APIC_BASE  = 16
) (
  input  logic [NUM_PIRQ-1:0]   pirq_i,
  input  logic                  sci_i,
  input  logic                  sci_valid_i,
  input  logic [IRQ_NUM_W-1:0]  sci_num_i,
  output logic [APIC_LINES-1:0] apic_o
);

  for (genvar j = 0; j < APIC_LINES; j++) begin : g_line
    logic sci_hit;
    assign sci_hit = sci_i && sci_valid_i && (sci_num_i == IRQ_NUM_W'(j));
    if (j >= APIC_BASE && j < APIC_BASE + NUM_PIRQ) begin : g_pirq
      assign apic_o[j] = pirq_i[j-APIC_BASE] | sci_hit;
    end else begin : g_sci_only
      assign apic_o[j] = sci_hit;
    end
  end

endmodule

// File: rtl/irq_steer_router.sv
module irq_steer_router
  import irq_steer_pkg::*;
#(
  parameter int NUM_PIRQ   = 8,
  parameter int PIC_LINES  = 16,
  parameter int APIC_LINES = 24,
  parameter int APIC_BASE  = 16,
  parameter int AW         = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PIRQ-1:0]   pirq_i,
  input  logic                  sci_i,
  input  logic                  cfg_we,
  input  logic [AW-1:0]         cfg_addr,
  input  logic [7:0]            cfg_wdata,
  output logic [PIC_LINES-1:0]  pic_o,
  output logic [APIC_LINES-1:0] apic_o
);

  route_t [NUM_PIRQ-1:0]   routes;
  logic [SCI_SEL_W-1:0]    sci_sel;
  logic                    sci_valid, sci_pic;
  logic [IRQ_NUM_W-1:0]    sci_num;
  logic [PIC_LINES-1:0]    pic_d, pic_q;
  logic [APIC_LINES-1:0]   apic_d, apic_q;
  logic                    all_dis;

  irq_route_regs #(.NUM_PIRQ(NUM_PIRQ), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .route_o(routes), .sci_sel_o(sci_sel)
  );

  assign {sci_valid, sci_num} = sci_decode(sci_sel);
  assign sci_pic = sci_valid && (sci_num < IRQ_NUM_W'(PIC_LINES));

  irq_pic_mux #(.NUM_PIRQ(NUM_PIRQ), .PIC_LINES(PIC_LINES)) u_pic (
    .pirq_i(pirq_i), .route_i(routes), .sci_i(sci_i), .sci_pic_i(sci_pic),
    .sci_num_i(sci_num), .pic_o(pic_d)
  );

  irq_apic_map #(.NUM_PIRQ(NUM_PIRQ), .APIC_LINES(APIC_LINES), .APIC_BASE(APIC_BASE)) u_apic (
    .pirq_i(pirq_i), .sci_i(sci_i), .sci_valid_i(sci_valid), .sci_num_i(sci_num),
    .apic_o(apic_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pic_q  <= '0;
      apic_q <= '0;
    end else begin
      pic_q  <= pic_d;
      apic_q <= apic_d;
    end
  end

  assign pic_o  = pic_q;
  assign apic_o = apic_q;

  always_comb begin
    all_dis = 1'b1;
    for (int n = 0; n < NUM_PIRQ; n++) if (!routes[n].dis) all_dis = 1'b0;
  end

  // R5: each PIRQ reaches its dedicated advanced line one cycle later
  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_chk
    assert_apic_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pirq_i[n] |=> apic_o[APIC_BASE+n]);
    assert_apic_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!pirq_i[n] && !(sci_i && sci_valid && sci_num == IRQ_NUM_W'(APIC_BASE+n)))
      |=> !apic_o[APIC_BASE+n]);
  end

  // R4: with every route disabled and no SCI on the legacy side, legacy lines stay low
  assert_pic_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (all_dis && !(sci_i && sci_pic)) |=> (pic_o == '0));

  // R7: a reserved SCI code with no PIRQ active leaves every line low
  assert_sci_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sci_valid && pirq_i == '0) |=> (pic_o == '0 && apic_o == '0));

  // R9: no source active means all outputs low on the next cycle
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sci_i && pirq_i == '0) |=> (pic_o == '0 && apic_o == '0));

  // R8: SCI on 20 or 21 never touches the legacy side
  assert_sci_apic_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sci_valid && !sci_pic && all_dis) |=> (pic_o == '0));

endmodule

// File: tb/irq_steer_router_tb.sv
module irq_steer_router_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [7:0]  pirq;
  logic        sci;
  logic        we;
  logic [3:0]  addr;
  logic [7:0]  wdata;
  logic [15:0] pic;
  logic [23:0] apic;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_route [8];
  logic [2:0] m_sel;

  irq_steer_router u_dut (
    .clk(clk), .rst_n(rst_n), .pirq_i(pirq), .sci_i(sci),
    .cfg_we(we), .cfg_addr(addr), .cfg_wdata(wdata),
    .pic_o(pic), .apic_o(apic)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int sci_target(input logic [2:0] s);
    case (s)
      3'd0: return 9;
      3'd1: return 10;
      3'd2: return 11;
      3'd4: return 20;
      3'd5: return 21;
      default: return -1;
    endcase
  endfunction

  function automatic logic [15:0] exp_pic();
    logic [15:0] e = '0;
    int t = sci_target(m_sel);
    for (int n = 0; n < 8; n++)
      if (!m_route[n][7] && pirq[n]) e[m_route[n][3:0]] = 1'b1;
    if (sci && t >= 0 && t < 16) e[t] = 1'b1;
    return e;
  endfunction

  function automatic logic [23:0] exp_apic();
    logic [23:0] e = '0;
    int t = sci_target(m_sel);
    for (int n = 0; n < 8; n++) e[16+n] = pirq[n];
    if (sci && t >= 0) e[t] = 1'b1;
    return e;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] ep, input logic [23:0] ea);
    checks++;
    if (pic !== ep || apic !== ea) begin
      fails++;
      $display("FAIL %s: pic=%h apic=%h expected pic=%h apic=%h", req, pic, apic, ep, ea);
    end
  endtask

  task automatic check_model(input string req);
    check(req, exp_pic(), exp_apic());
  endtask

  task automatic model_reset();
    for (int n = 0; n < 8; n++) m_route[n] = 8'h80;
    m_sel = 3'd0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
    if (a < 8) m_route[a] = d;
    else if (a == 8) m_sel = d[2:0];
  endtask

  task automatic apply(input logic [7:0] p, input logic s);
    pirq = p; sci = s;
    step();
  endtask

  // R1: reset values
  task automatic t_reset();
    pirq = 8'hFF; sci = 1'b1;
    rst_n = 1'b0;
    #(CLK_PERIOD*2);
    @(negedge clk);
    check("R1 during reset", 16'h0, 24'h0);
    rst_n = 1'b1;
    model_reset();
    apply(8'hFF, 1'b0);
    check("R1 routes disabled after reset", 16'h0, 24'hFF0000);
    apply(8'h00, 1'b1);
    check("R1 SCI default to 9", 16'h0200, 24'h000200);
  endtask

  // R2, R3: routing and sharing
  task automatic t_route();
    wr(4'd0, 8'h05);
    wr(4'd1, 8'h05);
    wr(4'd2, 8'h0E);
    wr(4'd7, 8'h70);
    apply(8'h01, 1'b0);
    check("R2 route byte 0 to line 5", 16'h0020, 24'h010000);
    apply(8'h03, 1'b0);
    check("R3 shared line 5", 16'h0020, 24'h030000);
    apply(8'h02, 1'b0);
    check("R3 second source alone", 16'h0020, 24'h020000);
    apply(8'h84, 1'b0);
    check("R2 bits 6:4 ignored, line 0 and 14", 16'h4001, 24'h840000);
    check_model("R3 model");
    wr(4'd12, 8'h03);
    apply(8'h87, 1'b0);
    check("R2 address 12 ignored", 16'h4021, 24'h870000);
  endtask

  // R4, R5
  task automatic t_disable();
    wr(4'd0, 8'h85);
    apply(8'h01, 1'b0);
    check("R4 disabled route drives no legacy line", 16'h0000, 24'h010000);
    apply(8'h03, 1'b0);
    check("R5 advanced lines independent of routes", 16'h0020, 24'h030000);
    for (int n = 0; n < 8; n++) begin
      apply(8'(1 << n), 1'b0);
      check_model("R5 walking PIRQ");
    end
  endtask

  // R6, R7, R8
  task automatic t_sci();
    for (int c = 0; c < 8; c++) begin
      wr(4'd8, 8'(c));
      apply(8'h00, 1'b1);
      if (sci_target(3'(c)) < 0) check("R7 reserved SCI code", 16'h0, 24'h0);
      else if (sci_target(3'(c)) >= 16) check_model("R8 SCI advanced only");
      else check_model("R6 SCI steering");
    end
    wr(4'd8, 8'd4);
    apply(8'h10, 1'b1);
    check("R6 SCI ORed with PIRQ on 20", 16'h0, 24'h100000);
    apply(8'h10, 1'b0);
    check("R6 PIRQ alone on 20", 16'h0, 24'h100000);
    wr(4'd8, 8'd1);
    wr(4'd3, 8'h0A);
    apply(8'h08, 1'b1);
    check("R8 SCI and PIRQ share legacy 10", 16'h0400, 24'h080400);
  endtask

  // R9: one cycle latency
  task automatic t_latency();
    apply(8'h00, 1'b0);
    pirq = 8'h08;
    #1;
    check("R9 before edge", 16'h0000, 24'h000000);
    step();
    check("R9 after one edge", 16'h0400, 24'h080000);
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    we = 1'b0; addr = '0; wdata = '0;
    model_reset();
    t_reset();
    t_route();
    t_disable();
    t_sci();
    t_latency();
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule